// File: doc/BRIEF.md
# System clock source selector and speed divider

This block produces two clocks for a processor subsystem: a peripheral clock and a CPU core clock. It builds both from one of four incoming clock sources. A 2-bit select input picks the source that drives the block. Code 00 picks the crystal oscillator input, which is also the default after reset. Codes 01, 10 and 11 pick fixed sources of 24 MHz, 30 MHz and 40 MHz.

A speed-mode input controls both outputs. In standard mode the outputs carry the selected clock halved. In double-speed mode the outputs carry the selected clock unchanged. An idle input stops the CPU core clock and leaves the peripheral clock running.

The select, mode and idle inputs may change at any time while the clocks run. Each change reaches the outputs without a runt pulse:
- A source change uses a break-before-make handshake. Each channel is synchronised to its own clock.
- A mode change takes effect only at an instant when the halved clock and the full clock are both low.
- Idle gating uses a latch that is open only while the clock is low.

Top module: `sysclk_gen`

## Requirements
- R1: With `src_sel` = 00, the selected source is `clk_src[0]` (oscillator input). After reset in standard mode, `clk_per` has exactly twice the period of `clk_src[0]`.
- R2: `src_sel` values 01, 10 and 11 select `clk_src[1]`, `clk_src[2]` and `clk_src[3]` (24, 30 and 40 MHz sources). The output period follows the newly chosen source once the switch has completed.
- R3: With `x2_mode` = 0 (standard mode), both `clk_per` and `clk_cpu` have twice the period of the selected source.
- R4: With `x2_mode` = 1 (double-speed mode), both outputs have the period of the selected source. The mode may be changed in either direction while running. A change is applied only while both the halved and the full clock are low.
- R5: While `rst_n` is low, both outputs are held low. After reset is released, the block runs in standard mode on the source chosen by `src_sel`.
- R6: A source change turns the old channel off on its own falling edge before the new channel is turned on on its own falling edge. At no time are two channels enabled together.
- R7: With `idle` = 1, `clk_cpu` stays low once the request has passed its synchroniser, while `clk_per` keeps toggling.
- R8: After `idle` returns to 0, `clk_cpu` resumes with the same period as `clk_per`.
- R9: Across every source and mode change, no high or low phase on `clk_per` or `clk_cpu` is shorter than half the period of the fastest source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | NSRC (4) | Candidate clocks; bit 0 is the oscillator input, bits 1..3 are the 24, 30 and 40 MHz sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | SEL_W (2) | Source select code; the value is the index into `clk_src` |
| x2_mode | input | 1 | 0 selects standard mode (halved output), 1 selects double-speed mode (full output) |
| idle | input | 1 | 1 stops the CPU core clock |
| clk_per | output | 1 | Peripheral clock |
| clk_cpu | output | 1 | CPU core clock, which is the peripheral clock gated by idle |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A wrong channel enable shows up as a wrong output period within a few source cycles of a select change. If two channels overlap, the merged clock produces high or low phases shorter than any valid half period.
- A wrong mode state shows up as a doubled or halved output period. A mode switch applied at the wrong instant shows up as a runt phase within one source cycle of the synchronised change.
- A gate latch that opens at the wrong time truncates a CPU clock pulse at the first idle edge. A stuck idle path leaves the CPU clock either running under idle or silent after release.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   localparam int SRC_COUNT_DEF  = 4;
   localparam int SYNC_DEPTH_DEF = 2;

   typedef enum logic [1:0] {
      SRC_OSC = 2'b00,
      SRC_F24 = 2'b01,
      SRC_F30 = 2'b10,
      SRC_F40 = 2'b11
   } src_code_e;

   typedef enum logic {
      MODE_HALF = 1'b0,
      MODE_FULL = 1'b1
   } speed_mode_e;

endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
   parameter int  STAGES  = sysclk_pkg::SYNC_DEPTH_DEF,
   parameter bit  RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("sysclk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/sysclk_srcmux.sv
module sysclk_srcmux #(
   parameter  int NSRC  = sysclk_pkg::SRC_COUNT_DEF,
   parameter  int SYNC  = sysclk_pkg::SYNC_DEPTH_DEF,
   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]  clk_src,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             clk_sys
);

   if (NSRC < 2) begin : g_bad_count
      $error("sysclk_srcmux: NSRC must be at least 2");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("sysclk_srcmux: SYNC must be at least 2");
   end

   logic [NSRC-1:0] chan_en;
   logic [NSRC-1:0] chan_busy;
   logic [NSRC-1:0] chan_req;
   logic [NSRC-1:0] chan_gated;

   for (genvar i = 0; i < NSRC; i++) begin : g_chan
      localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
      logic [SYNC-1:0] hs_pipe;

      assign chan_req[i] = (sel == SEL_W'(i)) && !(|(chan_busy & ~SELF));

      always_ff @(negedge clk_src[i] or negedge rst_n) begin
         if (!rst_n) begin
            hs_pipe <= '0;
         end else begin
            hs_pipe <= {hs_pipe[SYNC-2:0], chan_req[i]};
         end
      end

      assign chan_busy[i]  = |hs_pipe;
      assign chan_en[i]    = hs_pipe[SYNC-1];
      assign chan_gated[i] = clk_src[i] & chan_en[i];

      // R6: a channel comes on only when every other channel is already off
      assert_break_before_make_R6: assert property (
         @(negedge clk_src[i]) disable iff (!rst_n)
         $rose(chan_en[i]) |-> !(|(chan_en & ~SELF)))
         else $error("channel %0d enabled while another channel was on", i);
   end

   assign clk_sys = |chan_gated;

   // R6: never two channels driving the merged clock
   always_comb begin
      if (rst_n) begin
         assert_single_channel_R6: assert ($onehot0(chan_en))
            else $error("more than one source channel enabled");
      end
   end

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
   parameter int SYNC = sysclk_pkg::SYNC_DEPTH_DEF
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic mode_in,
   output logic clk_out
);

   if (SYNC < 2) begin : g_bad_sync
      $error("sysclk_div: SYNC must be at least 2");
   end

   logic mode_s;
   logic half_q;
   logic mode_eff;

   sysclk_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_mode_sync (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .d     (mode_in),
      .q     (mode_s)
   );

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
      end else begin
         half_q <= ~half_q;
      end
   end

   // the mode is applied on a falling edge while the halved clock is low,
   // so both mux inputs are low at the switching instant
   always_ff @(negedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         mode_eff <= sysclk_pkg::MODE_HALF;
      end else if (!half_q) begin
         mode_eff <= mode_s;
      end
   end

   assign clk_out = mode_eff ? clk_sys : half_q;

   // R4: a mode change is taken only while the halved clock was low
   assert_mode_switch_low_R4: assert property (
      @(negedge clk_sys) disable iff (!rst_n)
      (mode_eff != $past(mode_eff)) |-> ($past(half_q) == 1'b0))
      else $error("speed mode changed while halved clock was high");

endmodule

// File: rtl/sysclk_icg.sv
module sysclk_icg #(
   parameter int SYNC = sysclk_pkg::SYNC_DEPTH_DEF
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic stop_in,
   output logic gclk
);

   if (SYNC < 2) begin : g_bad_sync
      $error("sysclk_icg: SYNC must be at least 2");
   end

   logic stop_s;
   logic run_l;

   sysclk_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_stop_sync (
      .clk   (clk_in),
      .rst_n (rst_n),
      .d     (stop_in),
      .q     (stop_s)
   );

   always_latch begin
      if (!clk_in) begin
         run_l = !stop_s;
      end
   end

   assign gclk = clk_in & run_l;

   // R7: a stop request held over two edges keeps the gated clock low
   assert_idle_holds_low_R7: assert property (
      @(negedge clk_in) disable iff (!rst_n)
      (stop_s && $past(stop_s)) |-> !gclk)
      else $error("gated clock pulsed while idle was settled");

   // R8: with no stop request the full high phase passes through
   assert_run_passes_R8: assert property (
      @(negedge clk_in) disable iff (!rst_n)
      (!stop_s && !$past(stop_s)) |-> gclk)
      else $error("gated clock suppressed while running");

endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen #(
   parameter  int NSRC        = sysclk_pkg::SRC_COUNT_DEF,
   parameter  int SYNC_STAGES = sysclk_pkg::SYNC_DEPTH_DEF,
   localparam int SEL_W       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]  clk_src,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             x2_mode,
   input  logic             idle,
   output logic             clk_per,
   output logic             clk_cpu
);

   if (NSRC < 2) begin : g_bad_count
      $error("sysclk_gen: NSRC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sysclk_gen: SYNC_STAGES must be at least 2");
   end

   logic clk_sys;

   sysclk_srcmux #(.NSRC(NSRC), .SYNC(SYNC_STAGES)) u_srcmux (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .sel     (src_sel),
      .clk_sys (clk_sys)
   );

   sysclk_div #(.SYNC(SYNC_STAGES)) u_div (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .mode_in (x2_mode),
      .clk_out (clk_per)
   );

   sysclk_icg #(.SYNC(SYNC_STAGES)) u_icg (
      .clk_in  (clk_per),
      .rst_n   (rst_n),
      .stop_in (idle),
      .gclk    (clk_cpu)
   );

endmodule

// File: tb/sysclk_gen_tb.sv
`timescale 1ns/1ps
module sysclk_gen_tb;

   localparam realtime OSC_PERIOD_NS = 50.0;
   localparam realtime SETTLE_NS     = 1200.0;
   localparam realtime WINDOW_NS     = 800.0;
   localparam realtime WATCHDOG_NS   = 400000.0;
   localparam real     TOL_NS        = 0.01;
   localparam real     MIN_PHASE_NS  = 12.49;

   typedef struct packed {
      logic [1:0] sel;
      logic       x2;
      logic       idle;
      logic [1:0] div;
      logic       cpu_on;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 1'b0, 1'b0, 2'd2, 1'b1},
      '{2'd0, 1'b1, 1'b0, 2'd1, 1'b1},
      '{2'd1, 1'b1, 1'b0, 2'd1, 1'b1},
      '{2'd1, 1'b0, 1'b0, 2'd2, 1'b1},
      '{2'd2, 1'b0, 1'b0, 2'd2, 1'b1},
      '{2'd2, 1'b1, 1'b1, 2'd1, 1'b0},
      '{2'd3, 1'b1, 1'b0, 2'd1, 1'b1},
      '{2'd3, 1'b0, 1'b1, 2'd2, 1'b0},
      '{2'd0, 1'b0, 1'b0, 2'd2, 1'b1},
      '{2'd3, 1'b1, 1'b0, 2'd1, 1'b1}
   };

   logic       c0, c1, c2, c3;
   logic [3:0] clk_src;
   logic       rst_n;
   logic [1:0] src_sel;
   logic       x2_mode;
   logic       idle;
   logic       clk_per;
   logic       clk_cpu;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  track_on = 1'b0;

   int  per_edges = 0;
   int  cpu_edges = 0;
   real per_min = 1.0e9, cpu_min = 1.0e9;
   real per_last = 0.0, cpu_last = 0.0;
   bit  per_seen = 1'b0, cpu_seen = 1'b0;

   function automatic real half_of(int s);
      case (s)
         0: return OSC_PERIOD_NS / 2.0;
         1: return 20.833;
         2: return 16.667;
         default: return 12.5;
      endcase
   endfunction

   initial begin c0 = 1'b0; forever #(half_of(0)) c0 = ~c0; end
   initial begin c1 = 1'b0; forever #(half_of(1)) c1 = ~c1; end
   initial begin c2 = 1'b0; forever #(half_of(2)) c2 = ~c2; end
   initial begin c3 = 1'b0; forever #(half_of(3)) c3 = ~c3; end
   assign clk_src = {c3, c2, c1, c0};

   sysclk_gen u_dut (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .src_sel (src_sel),
      .x2_mode (x2_mode),
      .idle    (idle),
      .clk_per (clk_per),
      .clk_cpu (clk_cpu)
   );

   always @(posedge clk_per) per_edges++;
   always @(posedge clk_cpu) cpu_edges++;

   always @(clk_per) begin
      if (track_on && per_seen && ($realtime - per_last) < per_min)
         per_min = $realtime - per_last;
      per_last = $realtime;
      per_seen = track_on;
   end

   always @(clk_cpu) begin
      if (track_on && cpu_seen && ($realtime - cpu_last) < cpu_min)
         cpu_min = $realtime - cpu_last;
      cpu_last = $realtime;
      cpu_seen = track_on;
   end

   task automatic chk_real(input string tag, input real act, input real exp);
      n_cmp++;
      if ((act - exp) > TOL_NS || (exp - act) > TOL_NS) begin
         n_bad++;
         $display("FAIL %s actual %0.3f expected %0.3f", tag, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_min(input string tag, input real act, input real lim);
      n_cmp++;
      if (act < lim) begin
         n_bad++;
         $display("FAIL %s actual %0.3f expected >= %0.3f", tag, act, lim);
      end
   endtask

   task automatic period_per(output real p);
      realtime t0;
      @(posedge clk_per);
      @(posedge clk_per);
      t0 = $realtime;
      @(posedge clk_per);
      p = $realtime - t0;
   endtask

   task automatic period_cpu(output real p);
      realtime t0;
      @(posedge clk_cpu);
      @(posedge clk_cpu);
      t0 = $realtime;
      @(posedge clk_cpu);
      p = $realtime - t0;
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(WATCHDOG_NS);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R5 actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin
      real p, pc, exp_p;
      int  e0, e1;
      string tag;
      rst_n = 1'b0; src_sel = 2'd0; x2_mode = 1'b0; idle = 1'b0;

      // R5: outputs low in reset
      #(233.0);
      chk_int("R5 clk_per during reset", int'(clk_per), 0);
      chk_int("R5 clk_cpu during reset", int'(clk_cpu), 0);
      #(100.0);
      chk_int("R5 clk_per still low in reset", int'(clk_per), 0);
      rst_n = 1'b1;
      #(SETTLE_NS);
      track_on = 1'b1;

      // R1 and R5: default source, standard mode after reset
      period_per(p);
      chk_real("R1 R5 default peripheral period", p, 2.0 * OSC_PERIOD_NS);

      // vector walk over selects, modes and idle
      for (int v = 0; v < NVEC; v++) begin
         src_sel = VECS[v].sel;
         x2_mode = VECS[v].x2;
         idle    = VECS[v].idle;
         #(SETTLE_NS);
         exp_p = 2.0 * half_of(int'(VECS[v].sel)) * real'(VECS[v].div);
         tag = $sformatf("%s %s vec%0d clk_per period",
                         (VECS[v].sel == 2'd0) ? "R1" : "R2",
                         (VECS[v].div == 2'd2) ? "R3" : "R4", v);
         period_per(p);
         chk_real(tag, p, exp_p);
         if (VECS[v].cpu_on) begin
            period_cpu(pc);
            chk_real($sformatf("%s vec%0d clk_cpu period",
                     (VECS[v].div == 2'd2) ? "R3" : "R4", v), pc, exp_p);
         end else begin
            e0 = cpu_edges;
            e1 = per_edges;
            #(WINDOW_NS);
            chk_int($sformatf("R7 vec%0d clk_cpu edges in idle", v),
                    cpu_edges - e0, 0);
            n_cmp++;
            if (per_edges - e1 < 4) begin
               n_bad++;
               $display("FAIL R7 vec%0d clk_per edges in idle actual %0d expected >= 4",
                        v, per_edges - e1);
            end
         end
      end

      // R8: release from idle, CPU follows peripheral clock again
      src_sel = 2'd1; x2_mode = 1'b0; idle = 1'b1;
      #(SETTLE_NS);
      idle = 1'b0;
      #(SETTLE_NS);
      period_cpu(pc);
      chk_real("R8 clk_cpu period after idle release", pc, 4.0 * half_of(1));

      // R4 and R9: rapid mode toggling on the fastest source, ending in double speed
      src_sel = 2'd3; x2_mode = 1'b0;
      #(SETTLE_NS);
      for (int k = 0; k < 15; k++) begin
         #(37.0);
         x2_mode = ~x2_mode;
      end
      #(SETTLE_NS);
      period_per(p);
      chk_real("R4 clk_per after rapid mode toggles", p, 2.0 * half_of(3));

      // R6 and R9: return to the slowest source from the fastest
      src_sel = 2'd0; x2_mode = 1'b1;
      #(SETTLE_NS);
      period_per(p);
      chk_real("R2 R6 clk_per after fast to slow switch", p, OSC_PERIOD_NS);

      chk_min("R9 R6 shortest clk_per phase", per_min, MIN_PHASE_NS);
      chk_min("R9 shortest clk_cpu phase", cpu_min, MIN_PHASE_NS);

      done = 1'b1;
      report();
      $finish;
   end

endmodule